// File: doc/BRIEF.md
# SDRAM Command Sequencer and Pin Driver

This block sits between a memory controller's request logic and the SDRAM device. It takes one-cycle-or-held requests for an initial all-bank precharge, an auto refresh, a mode register load, a single-bank or all-bank precharge, a read and a write. It turns each accepted request into the correct pattern on the chip-select, row-strobe, column-strobe and write-enable pins, along with the multiplexed address and the bank select. Refresh scheduling, data buffering and the data bus are handled elsewhere.

A read or write is split into two phases. The row is opened with an ACTIVE command. A fixed number of cycles later the column phase issues READ or WRITE with the 8-bit column address, and the auto-precharge flag is placed on address bit 10. Every accepted request starts a busy window of fixed length. While that window is open, `cmdDone` stays high and new requests are refused. A delay line of flops times this window, as well as the row-to-column gap and the write-recovery guard. While the busy window is open, a page-mode stop input injects a burst-terminate command.

Top module: `sdram_cmd_seq`

## Requirements
- R1: A request is taken only on a rising edge where `cmdDone` is low. `cmdDone` then rises in the next cycle. Requests seen while `cmdDone` is high are dropped and never issued later.
- R2: `cmdDone` stays high for exactly BUSY_LEN cycles (default 8) after an accepted request. A request held continuously is taken again BUSY_LEN+1 cycles after the previous one.
- R3: When several requests are present together, the order of preference is init precharge, refresh, mode load, precharge, write, read.
- R4: For a read or write, ACTIVE (pins CS_N,RAS_N,CAS_N,WE_N = 0011) appears with the row address and bank in the cycle after acceptance. WRITE (0100) or READ (0101) follows exactly TRCD cycles later (default 3).
- R5: In the column command, address bits [7:0] carry the column, bit 10 carries the auto-precharge flag, bits 11, 9 and 8 are 0, and the bank is the one given with the row.
- R6: PRECHARGE is pin code 0010. For a precharge request, bit 10 equals `preAll`, the other address bits are 0, and the bank comes from `bankAddr`. The init precharge always drives bit 10 = 1 and bank 0.
- R7: REFRESH is pin code 0001 with address 0. LOAD MODE is pin code 0000 with the address equal to `modeWord` and bank 0.
- R8: No PRECHARGE (either kind) is issued until more than TWR cycles (default 6) after a WRITE column command. A held precharge request is issued in the first cycle the guard allows.
- R9: `pageStop` sampled high while `cmdDone` is high and no column command is due issues BURST STOP (0110) in the next cycle. `pageStop` while idle has no effect.
- R10: During reset, CKE is 0, the pins show NOP (0111) and `cmdDone` is 0. After reset, CKE is 1 and the pins show NOP in every cycle with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqInitPre | input | 1 | Request: all-bank precharge for power-up |
| reqRefresh | input | 1 | Request: auto refresh |
| reqModeLoad | input | 1 | Request: load mode register |
| reqPrecharge | input | 1 | Request: precharge, scope chosen by preAll |
| reqWrite | input | 1 | Request: activate then write |
| reqRead | input | 1 | Request: activate then read |
| pageStop | input | 1 | Terminate an open page burst |
| rowAddr | input | ROW_W | Row for ACTIVE |
| colAddr | input | COL_W | Column for READ/WRITE |
| bankAddr | input | BANK_W | Bank for ACTIVE and single-bank precharge |
| autoPre | input | 1 | Auto-precharge with the column command |
| preAll | input | 1 | Precharge all banks when high |
| modeWord | input | ROW_W | Value driven on the address for LOAD MODE |
| cmdDone | output | 1 | High during the busy window; requests refused |
| sdCke | output | 1 | Clock enable pin |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ROW_W | Multiplexed address pins |
| sdBa | output | BANK_W | Bank select pins |

## Verification
Suppose the busy delay line holds a token too long or loses it. `cmdDone` then shows the wrong pulse length at once, and a held request shows the wrong re-issue spacing one command later. If the row-to-column line is off by a stage, the READ or WRITE lands a cycle early or late relative to ACTIVE. A corrupt captured column or bank shows on the address pins TRCD cycles after acceptance. A write-recovery guard that clears early lets a PRECHARGE through too soon after a WRITE. A wrong priority shows in the very first pin code after a multi-request edge.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Pin pattern {CS_N, RAS_N, CAS_N, WE_N}
  typedef enum logic [3:0] {
    PIN_MODE = 4'b0000,
    PIN_REF  = 4'b0001,
    PIN_PRE  = 4'b0010,
    PIN_ACT  = 4'b0011,
    PIN_WR   = 4'b0100,
    PIN_RD   = 4'b0101,
    PIN_BST  = 4'b0110,
    PIN_NOP  = 4'b0111
  } pinCmd_e;

  // Where the address pins take their value from
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_ROW,
    SRC_PRE_SEL,
    SRC_PRE_ALL,
    SRC_MODE,
    SRC_COL
  } addrSrc_e;

  typedef struct packed {
    logic     capture;  // latch column, bank and auto-precharge
    pinCmd_e  cmd;
    addrSrc_e src;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_seq_tap.sv
module sdram_seq_tap #(
  parameter int LEN     = 8,
  parameter bit TAP_ANY = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic tapOut
);

  logic [LEN-1:0] stages;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) stages <= '0;
        else       stages <= load;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) stages <= '0;
        else       stages <= {stages[LEN-2:0], load};
      end
    end

    if (TAP_ANY) begin : g_any
      assign tapOut = |stages;
    end else begin : g_last
      assign tapOut = stages[LEN-1];
    end
  endgenerate

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int BUSY_LEN = 8,
  parameter int TRCD     = 3,
  parameter int TWR      = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqInitPre,
  input  logic       reqRefresh,
  input  logic       reqModeLoad,
  input  logic       reqPrecharge,
  input  logic       reqWrite,
  input  logic       reqRead,
  input  logic       pageStop,
  output seqStrobe_t strb,
  output logic       cmdDone
);

  localparam int NUM_REQ = 6;

  logic               wrBlock;
  logic               colIssue;
  logic               accept;
  logic               pendWrite;
  logic               selWrite;
  logic [NUM_REQ-1:0] elig;

  // Precharge of either kind is masked while write recovery runs
  assign elig = {reqRead, reqWrite, reqPrecharge & ~wrBlock,
                 reqModeLoad, reqRefresh, reqInitPre & ~wrBlock};
  assign accept = !cmdDone && (|elig);

  always_comb begin
    strb     = '{capture: 1'b0, cmd: PIN_NOP, src: SRC_NONE};
    selWrite = 1'b0;
    if (colIssue) begin
      strb.cmd = pendWrite ? PIN_WR : PIN_RD;
      strb.src = SRC_COL;
    end else if (accept) begin
      if (elig[0]) begin
        strb.cmd = PIN_PRE;  strb.src = SRC_PRE_ALL;
      end else if (elig[1]) begin
        strb.cmd = PIN_REF;
      end else if (elig[2]) begin
        strb.cmd = PIN_MODE; strb.src = SRC_MODE;
      end else if (elig[3]) begin
        strb.cmd = PIN_PRE;  strb.src = SRC_PRE_SEL;
      end else begin
        strb.cmd     = PIN_ACT;
        strb.src     = SRC_ROW;
        strb.capture = 1'b1;
        selWrite     = elig[4];
      end
    end else if (pageStop && cmdDone) begin
      strb.cmd = PIN_BST;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pendWrite <= 1'b0;
    else if (strb.capture) pendWrite <= selWrite;
  end

  // Busy window: token travels BUSY_LEN stages, busy while any is set
  sdram_seq_tap #(.LEN(BUSY_LEN), .TAP_ANY(1'b1)) busyTapI (
    .clk(clk), .rstN(rstN), .load(accept), .tapOut(cmdDone));

  // Row-to-column gap: column command when the token reaches the end
  sdram_seq_tap #(.LEN(TRCD), .TAP_ANY(1'b0)) rcdTapI (
    .clk(clk), .rstN(rstN), .load(strb.capture), .tapOut(colIssue));

  // Write recovery: precharge blocked while the token is in flight
  sdram_seq_tap #(.LEN(TWR), .TAP_ANY(1'b1)) wrTapI (
    .clk(clk), .rstN(rstN), .load(colIssue && pendWrite), .tapOut(wrBlock));

endmodule

// File: rtl/sdram_seq_dpath.sv
module sdram_seq_dpath
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic              autoPre,
  input  logic              preAll,
  input  logic [ROW_W-1:0]  modeWord,
  output logic              sdCke,
  output logic [3:0]        pinCode,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [BANK_W-1:0] sdBa
);

  logic [COL_W-1:0]  colQ;
  logic [BANK_W-1:0] bankQ;
  logic              apQ;
  pinCmd_e           pinQ;
  logic [ROW_W-1:0]  addrNext;
  logic [BANK_W-1:0] baNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ  <= '0;
      bankQ <= '0;
      apQ   <= 1'b0;
    end else if (strb.capture) begin
      colQ  <= colAddr;
      bankQ <= bankAddr;
      apQ   <= autoPre;
    end
  end

  always_comb begin
    addrNext = '0;
    baNext   = '0;
    case (strb.src)
      SRC_ROW: begin
        addrNext = rowAddr;
        baNext   = bankAddr;
      end
      SRC_PRE_SEL: begin
        addrNext[AP_BIT] = preAll;
        baNext           = bankAddr;
      end
      SRC_PRE_ALL: addrNext[AP_BIT] = 1'b1;
      SRC_MODE:    addrNext = modeWord;
      SRC_COL: begin
        addrNext[COL_W-1:0] = colQ;
        addrNext[AP_BIT]    = apQ;
        baNext              = bankQ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinQ   <= PIN_NOP;
      sdAddr <= '0;
      sdBa   <= '0;
      sdCke  <= 1'b0;
    end else begin
      pinQ   <= strb.cmd;
      sdAddr <= addrNext;
      sdBa   <= baNext;
      sdCke  <= 1'b1;
    end
  end

  assign pinCode = pinQ;

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int BANK_W   = 2,
  parameter int AP_BIT   = 10,
  parameter int BUSY_LEN = 8,
  parameter int TRCD     = 3,
  parameter int TWR      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqInitPre,
  input  logic              reqRefresh,
  input  logic              reqModeLoad,
  input  logic              reqPrecharge,
  input  logic              reqWrite,
  input  logic              reqRead,
  input  logic              pageStop,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  input  logic [BANK_W-1:0] bankAddr,
  input  logic              autoPre,
  input  logic              preAll,
  input  logic [ROW_W-1:0]  modeWord,
  output logic              cmdDone,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [BANK_W-1:0] sdBa
);

  seqStrobe_t strb;
  logic [3:0] pinCode;

  sdram_seq_ctrl #(.BUSY_LEN(BUSY_LEN), .TRCD(TRCD), .TWR(TWR)) ctrlI (
    .clk(clk), .rstN(rstN),
    .reqInitPre(reqInitPre), .reqRefresh(reqRefresh),
    .reqModeLoad(reqModeLoad), .reqPrecharge(reqPrecharge),
    .reqWrite(reqWrite), .reqRead(reqRead), .pageStop(pageStop),
    .strb(strb), .cmdDone(cmdDone));

  sdram_seq_dpath #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
                    .AP_BIT(AP_BIT)) dpathI (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rowAddr(rowAddr), .colAddr(colAddr), .bankAddr(bankAddr),
    .autoPre(autoPre), .preAll(preAll), .modeWord(modeWord),
    .sdCke(sdCke), .pinCode(pinCode), .sdAddr(sdAddr), .sdBa(sdBa));

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = pinCode;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10,
  parameter int TRCD   = 3,
  parameter int TWR    = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqRefresh,
  input logic             reqModeLoad,
  input logic             reqWrite,
  input logic             reqRead,
  input logic             cmdDone,
  input logic             sdCsN,
  input logic             sdRasN,
  input logic             sdCasN,
  input logic             sdWeN,
  input logic [ROW_W-1:0] sdAddr
);

  localparam logic [ROW_W-1:0] LOW_MASK = ROW_W'((1 << COL_W) - 1);
  localparam logic [ROW_W-1:0] AP_MASK  = ROW_W'(1 << AP_BIT);
  localparam logic [ROW_W-1:0] HI_MASK  = ~(LOW_MASK | AP_MASK);

  logic [3:0] pinNow;
  logic [7:0] actAge;
  logic [7:0] wrAge;

  assign pinNow = {sdCsN, sdRasN, sdCasN, sdWeN};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actAge <= 8'd0;
      wrAge  <= 8'hFF;
    end else begin
      if (pinNow == 4'b0011)      actAge <= 8'd1;
      else if (actAge != 8'hFF)   actAge <= actAge + 8'd1;
      if (pinNow == 4'b0100)      wrAge  <= 8'd1;
      else if (wrAge != 8'hFF)    wrAge  <= wrAge + 8'd1;
    end
  end

  AST_TAKEN_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (pinNow inside {4'b0011, 4'b0010, 4'b0001, 4'b0000}) |-> !$past(cmdDone)); // R1

  AST_DONE_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdDone && (reqRefresh || reqModeLoad || reqWrite || reqRead)) |=> cmdDone); // R1

  AST_COL_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (pinNow inside {4'b0100, 4'b0101}) |-> (actAge == 8'(TRCD))); // R4

  AST_COL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pinNow inside {4'b0100, 4'b0101}) |-> ((sdAddr & HI_MASK) == '0)); // R5

  AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    (pinNow == 4'b0010) |-> (32'(wrAge) > TWR)); // R8

  AST_BST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (pinNow == 4'b0110) |-> $past(cmdDone)); // R9

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .TRCD(TRCD), .TWR(TWR)
) chkI (
  .clk(clk), .rstN(rstN), .reqRefresh(reqRefresh), .reqModeLoad(reqModeLoad),
  .reqWrite(reqWrite), .reqRead(reqRead), .cmdDone(cmdDone),
  .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
  .sdAddr(sdAddr));

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb_top;

  localparam int BUSY_LEN = 8;
  localparam int TRCD     = 3;
  localparam int TWR      = 6;

  localparam logic [3:0] C_MODE = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_BST = 4'b0110, C_NOP = 4'b0111;

  // mask bits: 0 initPre, 1 refresh, 2 mode, 3 precharge, 4 write, 5 read
  typedef struct packed {
    logic [5:0]  mask;
    logic [11:0] row;
    logic [7:0]  col;
    logic [1:0]  bank;
    logic        ap;
    logic        pa;
    logic [11:0] mode;
    logic [3:0]  expCode;
    logic [11:0] expAddr;
    logic [1:0]  expBa;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{6'b000010, 12'h000, 8'h00, 2'd0, 1'b0, 1'b0, 12'h000, C_REF,  12'h000, 2'd0},
    '{6'b000100, 12'h000, 8'h00, 2'd1, 1'b0, 1'b0, 12'h037, C_MODE, 12'h037, 2'd0},
    '{6'b000001, 12'h000, 8'h00, 2'd3, 1'b0, 1'b0, 12'h000, C_PRE,  12'h400, 2'd0},
    '{6'b001000, 12'hFFF, 8'h00, 2'd2, 1'b0, 1'b0, 12'h000, C_PRE,  12'h000, 2'd2},
    '{6'b010000, 12'hABC, 8'h5A, 2'd1, 1'b1, 1'b0, 12'h000, C_ACT,  12'hABC, 2'd1},
    '{6'b100000, 12'h123, 8'hF0, 2'd3, 1'b0, 1'b1, 12'h000, C_ACT,  12'h123, 2'd3},
    '{6'b001000, 12'h000, 8'h00, 2'd1, 1'b0, 1'b1, 12'h000, C_PRE,  12'h400, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqInitPre = 1'b0, reqRefresh = 1'b0, reqModeLoad = 1'b0;
  logic        reqPrecharge = 1'b0, reqWrite = 1'b0, reqRead = 1'b0;
  logic        pageStop = 1'b0;
  logic [11:0] rowAddr = '0;
  logic [7:0]  colAddr = '0;
  logic [1:0]  bankAddr = '0;
  logic        autoPre = 1'b0, preAll = 1'b0;
  logic [11:0] modeWord = '0;
  logic        cmdDone, sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [11:0] sdAddr;
  logic [1:0]  sdBa;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int busyRun = 0;
  int lastRun = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmdDone) busyRun <= busyRun + 1;
    else if (busyRun != 0) begin
      lastRun <= busyRun;
      busyRun <= 0;
    end
  end

  sdram_cmd_seq #(.BUSY_LEN(BUSY_LEN), .TRCD(TRCD), .TWR(TWR)) dut_i (
    .clk(clk), .rstN(rstN), .reqInitPre(reqInitPre), .reqRefresh(reqRefresh),
    .reqModeLoad(reqModeLoad), .reqPrecharge(reqPrecharge),
    .reqWrite(reqWrite), .reqRead(reqRead), .pageStop(pageStop),
    .rowAddr(rowAddr), .colAddr(colAddr), .bankAddr(bankAddr),
    .autoPre(autoPre), .preAll(preAll), .modeWord(modeWord),
    .cmdDone(cmdDone), .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN),
    .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr), .sdBa(sdBa));

  function automatic logic [3:0] code();
    return {sdCsN, sdRasN, sdCasN, sdWeN};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic setReqs(input logic [5:0] m);
    {reqRead, reqWrite, reqPrecharge, reqModeLoad, reqRefresh, reqInitPre} = m;
  endtask

  task automatic waitIdle();
    while (cmdDone) @(negedge clk);
  endtask

  // Drive a request until it is taken; returns at the negedge after acceptance
  task automatic issue(input logic [5:0] m, input vec_t v);
    @(negedge clk);
    rowAddr = v.row; colAddr = v.col; bankAddr = v.bank;
    autoPre = v.ap; preAll = v.pa; modeWord = v.mode;
    setReqs(m);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cmdDone) break;
    end
    setReqs(6'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    // Reset state (R10, R1)
    repeat (3) @(negedge clk);
    check("R10", "reset pins", 32'(code()), 32'(C_NOP));
    check("R10", "reset cke", 32'(sdCke), 32'd0);
    check("R1", "reset cmdDone", 32'(cmdDone), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "cke after reset", 32'(sdCke), 32'd1);
    check("R10", "idle pins", 32'(code()), 32'(C_NOP));

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = (v.mask[0] || v.mask[3]) ? "R6" : (v.mask[1] || v.mask[2]) ? "R7" : "R4";
      waitIdle();
      issue(v.mask, v);
      check(tag, "first code", 32'(code()), 32'(v.expCode));
      check(tag, "first addr", 32'(sdAddr), 32'(v.expAddr));
      check(tag, "first bank", 32'(sdBa), 32'(v.expBa));
      if (v.mask[4] || v.mask[5]) begin
        repeat (TRCD) @(negedge clk);
        check("R4", "column code", 32'(code()), 32'(v.mask[4] ? C_WR : C_RD));
        check("R5", "column addr", 32'(sdAddr), 32'({1'b0, v.ap, 2'b00, v.col}));
        check("R5", "column bank", 32'(sdBa), 32'(v.bank));
        @(negedge clk);
        check("R10", "nop after column", 32'(code()), 32'(C_NOP));
      end
      waitIdle();
      @(negedge clk);
      check("R2", "busy length", 32'(lastRun), 32'(BUSY_LEN));
    end

    // R1: request during busy window is dropped
    begin
      vec_t v;
      int seenMode;
      v = VECS[0];
      waitIdle();
      issue(6'b000010, v);
      seenMode = 0;
      reqModeLoad = 1'b1;
      repeat (2) @(negedge clk);
      reqModeLoad = 1'b0;
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        if (code() == C_MODE) seenMode++;
      end
      check("R1", "mode issued from busy window", 32'(seenMode), 32'd0);
      check("R1", "cmdDone after window", 32'(cmdDone), 32'd0);
    end

    // R2: held request re-taken after BUSY_LEN+1 cycles
    begin
      int firstCyc, secondCyc;
      firstCyc = -1; secondCyc = -1;
      @(negedge clk);
      reqRefresh = 1'b1;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (code() == C_REF) begin
          if (firstCyc < 0) firstCyc = cyc;
          else if (secondCyc < 0) secondCyc = cyc;
        end
      end
      reqRefresh = 1'b0;
      check("R2", "held refresh spacing", 32'(secondCyc - firstCyc), 32'(BUSY_LEN + 1));
      waitIdle();
    end

    // R3: priority among simultaneous requests
    begin
      vec_t v;
      v = VECS[5];
      waitIdle();
      issue(6'b100010, v);
      check("R3", "refresh beats read", 32'(code()), 32'(C_REF));
      waitIdle();
      issue(6'b110000, v);
      check("R3", "write beats read (activate)", 32'(code()), 32'(C_ACT));
      repeat (TRCD) @(negedge clk);
      check("R3", "write beats read (column)", 32'(code()), 32'(C_WR));
      waitIdle();
      issue(6'b001101, v);
      check("R3", "init precharge beats mode", 32'(sdAddr), 32'h400);
    end

    // R8: precharge held back by write recovery
    begin
      vec_t v;
      int colCyc, preCyc, expGap;
      v = VECS[4];
      waitIdle();
      issue(6'b010000, v);
      repeat (TRCD) @(negedge clk);
      colCyc = cyc;
      preCyc = -1;
      preAll = 1'b1;
      reqPrecharge = 1'b1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (code() == C_PRE) begin
          preCyc = cyc;
          break;
        end
      end
      reqPrecharge = 1'b0;
      expGap = ((TRCD + TWR + 1) > (BUSY_LEN + 1) ? (TRCD + TWR + 1) : (BUSY_LEN + 1)) - TRCD;
      check("R8", "write to precharge gap", 32'(preCyc - colCyc), 32'(expGap));
      waitIdle();
    end

    // R9: burst stop during a read, ignored while idle
    begin
      vec_t v;
      v = VECS[5];
      waitIdle();
      issue(6'b100000, v);
      repeat (TRCD) @(negedge clk);
      pageStop = 1'b1;
      @(negedge clk);
      pageStop = 1'b0;
      check("R9", "burst stop code", 32'(code()), 32'(C_BST));
      @(negedge clk);
      check("R10", "nop after burst stop", 32'(code()), 32'(C_NOP));
      waitIdle();
      @(negedge clk);
      pageStop = 1'b1;
      @(negedge clk);
      pageStop = 1'b0;
      check("R9", "idle stop pins", 32'(code()), 32'(C_NOP));
      check("R9", "idle stop cmdDone", 32'(cmdDone), 32'd0);
    end

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule